// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block resets the system when software stops servicing it. A watchdog tick input, one pulse per watchdog clock period, is slowed by a selectable power-of-two prescaler. The prescaled tick advances an 8-bit counter. If that counter rolls over, the block raises a system reset request.

Software keeps the counter away from rollover through a key address. It must write an arming key first and a clearing key after it. A key value the block does not know is treated as a fault, and so is a control write whose check field is wrong. Either fault raises the reset request at once, without waiting for the counter.

A sticky cause flag records that the watchdog fired. A plain reset does not clear it, so software can read after a restart why the restart happened. A disable bit can stop counting, but only while an external override input is high. All register accesses are synchronous to `clk`, and reads return their data one cycle after the address is presented.

Top module: `keyed_watchdog`

## Requirements
- R1: The prescale field (control bits 2:0) picks the tick rate. Codes 000 and 001 count every `wd_tick` pulse. Codes 010 to 111 count one pulse in 2, 4, 8, 16, 32 and 64, measured from the last reset.
- R2: Each prescaled tick adds one to an 8-bit counter. A tick that finds the counter at FFh wraps it to 00h and raises a fault.
- R3: A write of 55h to the key address (1) arms the block, and further 55h writes keep it armed. A following AAh write clears the counter to zero and disarms the block. An AAh write while not armed changes nothing.
- R4: A write to the key address of any value other than 55h or AAh raises a fault.
- R5: A control write (address 0) must carry 101 in bits 5:3. Any other pattern raises a fault, and the write is discarded. A valid write loads the disable bit from bit 6 and the prescale field from bits 2:0.
- R6: A fault detected on one clock edge drives `sys_rst_req` high for the single cycle that follows the next edge.
- R7: Every fault sets the cause flag (control bit 7). `rst` leaves the flag unchanged. Only `por`, or a valid control write with bit 7 set, clears it. A valid control write with bit 7 clear leaves it unchanged.
- R8: The disable bit freezes the counter and the prescaler only while `wd_override` is high. When `wd_override` is low, counting continues.
- R9: `rst` or `por` clears the prescale field, the disable bit, the counter and the armed state. Counting resumes on the first tick after release.
- R10: Reads are registered. Address 0 returns {8'h00, flag, disable, 3'b000, prescale}. Address 2 returns the counter in bits 7:0. Addresses 1 and 3 return zero.
- R11: When a clearing AAh write arrives in the same cycle as a tick that would roll the counter over, the clear wins. The counter becomes zero and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous system reset, active high; keeps the cause flag |
| por | input | 1 | Synchronous power-on reset, active high; clears everything |
| wd_tick | input | 1 | One pulse per watchdog clock period |
| wd_override | input | 1 | Lets the disable bit take effect while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 key |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| sys_rst_req | output | 1 | Registered system reset request |

## Verification
Two events can land on the same edge: a prescaled tick that finds the counter at FFh, and a clearing AAh write that follows an earlier 55h. The bench arms the block and counts up to FFh. It then raises `wd_tick` and writes AAh to the key address in the same cycle. The test passes if the counter reads back zero and `sys_rst_req` stays low for the two cycles after that edge.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;
  localparam logic [7:0] KEY_ARM   = 8'h55;
  localparam logic [7:0] KEY_CLEAR = 8'hAA;
  localparam logic [2:0] CHK_GOOD  = 3'b101;

  localparam int unsigned BIT_FLAG = 7;
  localparam int unsigned BIT_DIS  = 6;
  localparam int unsigned CHK_LSB  = 3;
  localparam int unsigned PS_LSB   = 0;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_KEY   = 2'd1,
    A_COUNT = 2'd2,
    A_SPARE = 2'd3
  } wd_addr_e;
endpackage

// File: rtl/wd_prescale.sv
module wd_prescale #(
  parameter int unsigned DIV_W = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wd_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o
);
  localparam int unsigned NTAP = DIV_W + 1;

  logic [DIV_W-1:0] div_cnt;
  logic [NTAP-1:0]  taps;
  logic [SEL_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst)                 div_cnt <= '0;
    else if (run && wd_tick) div_cnt <= div_cnt + 1'b1;
  end

  assign taps[0] = wd_tick;
  generate
    for (genvar k = 1; k < NTAP; k++) begin : g_tap
      assign taps[k] = wd_tick & (&div_cnt[k-1:0]);
    end
  endgenerate

  always_comb begin
    if (sel < SEL_W'(2)) idx = '0;
    else                 idx = sel - 1'b1;
    if (int'(idx) >= NTAP) idx = SEL_W'(NTAP - 1);
  end

  assign tick_o = run & taps[idx];
endmodule

// File: rtl/wd_key.sv
module wd_key
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_key,
  input  logic [KEY_W-1:0] key,
  output logic             clear_o,
  output logic             bad_o,
  output logic             armed_o
);
  logic armed;
  logic is_arm, is_clr;

  assign is_arm  = (key == KEY_W'(KEY_ARM));
  assign is_clr  = (key == KEY_W'(KEY_CLEAR));
  assign clear_o = wr_key && is_clr && armed;
  assign bad_o   = wr_key && !is_arm && !is_clr;
  assign armed_o = armed;

  always_ff @(posedge clk) begin
    if (rst)                armed <= 1'b0;
    else if (wr_key) begin
      if (is_arm)           armed <= 1'b1;
      else                  armed <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              wd_tick,
  input  logic              wd_override,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_req
);
  localparam int unsigned KEY_W = 8;

  logic             any_rst;
  logic             wr_ctrl, wr_key, ctrl_ok, ctrl_bad;
  logic             key_clear, key_bad, armed;
  logic             tick, ovf, fault, hold;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] ps;
  logic             dis, flag, pend;

  assign any_rst  = rst | por;
  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_key   = wr_en && (wr_addr == ADDR_W'(A_KEY));
  assign ctrl_ok  = wr_ctrl && (wr_data[CHK_LSB +: 3] == CHK_GOOD);
  assign ctrl_bad = wr_ctrl && !ctrl_ok;
  assign hold     = dis && wd_override;

  wd_prescale #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst     (any_rst),
    .run     (!hold),
    .wd_tick (wd_tick),
    .sel     (ps),
    .tick_o  (tick)
  );

  wd_key #(.KEY_W(KEY_W)) u_key (
    .clk     (clk),
    .rst     (any_rst),
    .wr_key  (wr_key),
    .key     (wr_data[KEY_W-1:0]),
    .clear_o (key_clear),
    .bad_o   (key_bad),
    .armed_o (armed)
  );

  assign ovf   = tick && (&cnt) && !key_clear;
  assign fault = ovf || key_bad || ctrl_bad;

  always_ff @(posedge clk) begin
    if (any_rst)        cnt <= '0;
    else if (key_clear) cnt <= '0;
    else if (tick)      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      ps  <= '0;
      dis <= 1'b0;
    end else if (ctrl_ok) begin
      ps  <= wr_data[PS_LSB +: SEL_W];
      dis <= wr_data[BIT_DIS];
    end
  end

  always_ff @(posedge clk) begin
    if (por)                            flag <= 1'b0;
    else if (fault)                     flag <= 1'b1;
    else if (ctrl_ok && wr_data[BIT_FLAG]) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      pend        <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      pend        <= fault;
      sys_rst_req <= pend;
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (rd_addr)
        ADDR_W'(A_CTRL): begin
          rd_data[BIT_FLAG]          <= flag;
          rd_data[BIT_DIS]           <= dis;
          rd_data[PS_LSB +: SEL_W]   <= ps;
        end
        ADDR_W'(A_COUNT): rd_data[CNT_W-1:0] <= cnt;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             por,
  input logic             fault,
  input logic             sys_rst_req,
  input logic             flag,
  input logic             key_clear,
  input logic             hold,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] ps
);
  AST_REQ_DELAY: assert property (@(posedge clk) disable iff (rst || por)
    fault |=> ##1 sys_rst_req); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (por)
    fault |=> flag); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst || por)
    key_clear |=> (cnt == '0)); // R3
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst || por)
    (hold && !key_clear) |=> $stable(cnt)); // R8
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (1'b0)
    (rst || por) |=> (cnt == '0 && ps == '0)); // R9
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .por         (por),
  .fault       (fault),
  .sys_rst_req (sys_rst_req),
  .flag        (flag),
  .key_clear   (key_clear),
  .hold        (hold),
  .cnt         (cnt),
  .ps          (ps)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1, por = 1'b1;
  logic        wd_tick = 1'b0, wd_override = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sys_rst_req;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_watchdog u_dut (
    .clk(clk), .rst(rst), .por(por), .wd_tick(wd_tick), .wd_override(wd_override),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .sys_rst_req(sys_rst_req)
  );

  // {addr, data, expect fault}
  localparam logic [18:0] VEC [9] = '{
    {2'd0, 16'h0028, 1'b0},
    {2'd0, 16'h0010, 1'b1},
    {2'd1, 16'h0055, 1'b0},
    {2'd1, 16'h00AA, 1'b0},
    {2'd1, 16'h00AA, 1'b0},
    {2'd1, 16'h0023, 1'b1},
    {2'd0, 16'h002F, 1'b0},
    {2'd1, 16'h0000, 1'b1},
    {2'd0, 16'h0000, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_por();
    por = 1'b1; step(); por = 1'b0;
  endtask

  task automatic do_rst();
    rst = 1'b1; step(); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; step(); d = rd_data;
  endtask

  task automatic ticks(input int n);
    wd_tick = 1'b1;
    for (int i = 0; i < n; i++) @(posedge clk);
    #1 wd_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    step(); step();
    rst = 1'b0; por = 1'b0;

    // R9 R10: reset state
    chk("R6 req idle after reset", {15'd0, sys_rst_req}, 16'd0);
    rd(2'd0, v); chk("R9 ctrl after reset", v, 16'h0000);
    rd(2'd2, v); chk("R9 count after reset", v, 16'h0000);
    rd(2'd1, v); chk("R10 key reads zero", v, 16'h0000);
    rd(2'd3, v); chk("R10 spare reads zero", v, 16'h0000);

    // R4 R5 R6 vector walk
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][18:17], VEC[i][16:1]);
      chk("R6 no req one cycle after write", {15'd0, sys_rst_req}, 16'd0);
      step();
      chk("R4/R5 fault req vector", {15'd0, sys_rst_req}, {15'd0, VEC[i][0]});
      if (VEC[i][0]) do_rst();
    end

    // R1 R2 R9: prescale taps
    do_por();
    ticks(1); rd(2'd2, v); chk("R9 counts right after reset", v, 16'd1);
    do_por(); ticks(20); rd(2'd2, v); chk("R2 code000 count", v, 16'd20);
    do_por(); wr(2'd0, 16'h0029); ticks(10); rd(2'd2, v); chk("R1 code001 div1", v, 16'd10);
    do_por(); wr(2'd0, 16'h002B); ticks(16); rd(2'd2, v); chk("R1 code011 div4", v, 16'd4);
    do_por(); wr(2'd0, 16'h002F); ticks(128); rd(2'd2, v); chk("R1 code111 div64", v, 16'd2);
    rd(2'd0, v); chk("R10 ctrl readback ps", v, 16'h0007);
    wr(2'd0, 16'h0011); step(); do_rst();
    rd(2'd0, v); chk("R5 bad check write discarded", v & 16'h0047, 16'h0000);

    // R3: key sequence
    do_por(); ticks(10);
    wr(2'd1, 16'h00AA); rd(2'd2, v); chk("R3 unarmed AA ignored", v, 16'd10);
    chk("R3 unarmed AA no req", {15'd0, sys_rst_req}, 16'd0);
    wr(2'd1, 16'h0055); wr(2'd1, 16'h0055); wr(2'd1, 16'h00AA);
    rd(2'd2, v); chk("R3 55 55 AA clears", v, 16'd0);
    ticks(3); wr(2'd1, 16'h00AA); rd(2'd2, v); chk("R3 disarmed after clear", v, 16'd3);

    // R2 R6 R7: overflow
    do_por(); ticks(255);
    rd(2'd2, v); chk("R2 count at FF", v, 16'h00FF);
    ticks(1);
    chk("R6 req low on fault edge", {15'd0, sys_rst_req}, 16'd0);
    step(); chk("R6 req high after delay", {15'd0, sys_rst_req}, 16'd1);
    step(); chk("R6 req single cycle", {15'd0, sys_rst_req}, 16'd0);
    rd(2'd2, v); chk("R2 wrap to zero", v, 16'd0);
    rd(2'd0, v); chk("R7 flag set by overflow", v, 16'h0080);

    // R7: flag persistence
    do_rst(); rd(2'd0, v); chk("R7 flag survives rst", v, 16'h0080);
    wr(2'd0, 16'h0028); rd(2'd0, v); chk("R7 write 0 keeps flag", v, 16'h0080);
    wr(2'd0, 16'h00A8); rd(2'd0, v); chk("R7 write 1 clears flag", v, 16'h0000);
    wr(2'd1, 16'h0042); step(); do_rst();
    rd(2'd0, v); chk("R7 bad key sets flag", v, 16'h0080);
    do_por(); rd(2'd0, v); chk("R7 por clears flag", v, 16'h0000);

    // R8: disable with override
    do_por(); wr(2'd0, 16'h0068); ticks(5);
    rd(2'd2, v); chk("R8 disable ignored without override", v, 16'd5);
    wd_override = 1'b1; ticks(5);
    rd(2'd2, v); chk("R8 frozen with override", v, 16'd5);
    rd(2'd0, v); chk("R10 ctrl shows disable", v, 16'h0040);
    wd_override = 1'b0; ticks(2);
    rd(2'd2, v); chk("R8 resumes on override low", v, 16'd7);

    // R11: clear and overflow on the same edge
    do_por(); wr(2'd1, 16'h0055); ticks(255);
    wd_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h00AA;
    step(); wd_tick = 1'b0; wr_en = 1'b0;
    chk("R11 no req edge+1", {15'd0, sys_rst_req}, 16'd0);
    step(); chk("R11 no req edge+2", {15'd0, sys_rst_req}, 16'd0);
    rd(2'd2, v); chk("R11 clear wins", v, 16'd0);
    rd(2'd0, v); chk("R11 flag untouched", v, 16'h0000);

    finish_run();
  end
endmodule